// File: doc/BRIEF.md
# Power-Gating Interval Timer

This block drives an active-high enable that switches a downstream regulator, and with it a processor, on and off at a programmed interval. It counts a 1 ms tick enable. At the start of each interval it raises the enable. It drops the enable early when the powered processor reports that its work is finished with a rising edge on DONE. It always keeps the enable low for the final 50 ticks of an interval, so the supply gets a guaranteed rest before the next cycle.

Configuration is presented once, when a configuration-valid strobe rises. Two modes are available. The periodic mode repeats the interval forever. The single-shot mode gives one pulse after configuration and then stays parked until a manual start arrives from an external power-on detector. The detector has already debounced that input. Status outputs show whether the block is configured, whether DONE ended the current pulse, and whether the last completed interval went unacknowledged.

Top module: `pgt_timer_top`

## Requirements
- R1: While reset is asserted, and after it until configuration, `drv_en`, `cfg_locked`, `ack_seen` and `no_ack` are low. On the first clock edge at which `cfg_valid` is sampled high after being low, the block starts the first interval: `drv_en` is high after that edge and `cfg_locked` goes high.
- R2: In periodic mode (`cfg_periodic` = 1), consecutive rising edges of `drv_en` are exactly one interval of ticks apart.
- R3: Without an accepted DONE, `drv_en` stays high for the interval minus 50 ticks. It is then low for the remaining 50 ticks of the interval.
- R4: `done_in` passes through a two-flop synchroniser. A low-to-high change ends the pulse: `drv_en` is low after the third clock edge that samples `done_in` high. It then stays low for the rest of the interval. DONE edges after the first in an interval, and edges while `drv_en` is low, have no effect.
- R5: In single-shot mode (`cfg_periodic` = 0), one pulse follows configuration. `drv_en` then stays low until a manual start is accepted.
- R6: A rising edge on `man_start` while `drv_en` is low starts a fresh interval from tick zero in either mode, and `drv_en` is high after that clock edge. A rising edge while `drv_en` is high is ignored.
- R7: A DONE edge that reaches the controller while `man_start` is high is ignored.
- R8: The mode and interval are captured once. Later changes of `cfg_valid`, `cfg_periodic` and `cfg_interval` have no effect until reset.
- R9: The interval is bounded to between 100 and 7 200 000 ticks. A smaller value is taken as 100 and a larger value as 7 200 000.
- R10: `ack_seen` is set when a DONE edge is accepted and cleared when a new interval starts. `no_ack` is updated at the end of each completed interval and is high when that interval had no accepted DONE.
- R11: The interval counter advances only on clock edges where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable per timing tick (1 ms) |
| cfg_valid | input | 1 | Configuration strobe; its first rise captures mode and interval |
| cfg_periodic | input | 1 | 1 = periodic mode, 0 = single-shot mode |
| cfg_interval | input | 23 | Interval length in ticks |
| done_in | input | 1 | Asynchronous completion signal from the powered processor |
| man_start | input | 1 | Debounced manual power-on level from the detector |
| drv_en | output | 1 | Regulator enable, active high |
| cfg_locked | output | 1 | Configuration has been captured |
| ack_seen | output | 1 | DONE ended the pulse of the current interval |
| no_ack | output | 1 | Last completed interval had no accepted DONE |

## Verification
The assertions assume the following about the inputs:
- `done_in` stays high for at least three clock cycles, and any rise of it that matters happens while the enable is high. This lets the checker link an accepted DONE to a DONE level it saw during the pulse.
- `man_start` is a clean synchronous level.
- The configuration inputs are stable while `cfg_valid` rises.

The stimulus meets these assumptions. It changes every input on the falling clock edge. It holds each DONE pulse for several cycles and drops it only once the enable is low. It sets the configuration fields in the same cycle as the strobe and leaves them unchanged from then on, except in the one test that deliberately rewrites them after capture.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_ON    = 2'd1,
        ST_OFF   = 2'd2,
        ST_PARK  = 2'd3
    } pgt_state_e;

    typedef enum logic {
        MODE_SINGLE   = 1'b0,
        MODE_PERIODIC = 1'b1
    } pgt_mode_e;

    // events produced by the interval counter on a tick
    typedef struct packed {
        logic cut;   // enable must drop: rest window begins
        logic last;  // final tick of the interval
    } pgt_ctr_ev_t;

    // controls from the sequencer to the counter
    typedef struct packed {
        logic clr;   // restart counting from zero
        logic run;   // an interval is in progress
    } pgt_ctl_t;

    function automatic logic [31:0] pgt_clamp(input logic [31:0] v,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        return v;
    endfunction

endpackage

// File: rtl/pgt_edge_det.sv
module pgt_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic level,
    output logic rise
);

    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign level = d_in;
        end else begin : g_sync
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst)
                    sr <= '0;
                else
                    sr <= (sr << 1) | STAGES'(d_in);
            end
            assign level = sr[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b0;
        else
            prev <= level;
    end

    assign rise = level & ~prev;

endmodule

// File: rtl/pgt_cfg_latch.sv
module pgt_cfg_latch
    import pgt_pkg::*;
#(
    parameter int MIN_TICKS = 100,
    parameter int MAX_TICKS = 7200000,
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  logic             cfg_periodic,
    input  logic [CNT_W-1:0] cfg_interval,
    output logic             go,
    output logic             locked,
    output pgt_mode_e        mode,
    output logic [CNT_W-1:0] len
);

    logic valid_q;
    logic [CNT_W-1:0] bounded;

    assign bounded = CNT_W'(pgt_clamp(32'(cfg_interval), 32'(MIN_TICKS), 32'(MAX_TICKS)));
    assign go      = cfg_valid & ~valid_q & ~locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            locked  <= 1'b0;
            mode    <= MODE_SINGLE;
            len     <= CNT_W'(MIN_TICKS);
        end else begin
            valid_q <= cfg_valid;
            if (go) begin
                locked <= 1'b1;
                mode   <= pgt_mode_e'(cfg_periodic);
                len    <= bounded;
            end
        end
    end

endmodule

// File: rtl/pgt_interval_ctr.sv
module pgt_interval_ctr
    import pgt_pkg::*;
#(
    parameter int MAX_TICKS = 7200000,
    parameter int OFF_TICKS = 50,
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  pgt_ctl_t         ctl,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output pgt_ctr_ev_t      ev
);

    logic [CNT_W-1:0] cnt;
    logic             step;

    assign step    = ctl.run & tick;
    assign ev.last = step & (cnt == len - CNT_W'(1));
    assign ev.cut  = step & (cnt == len - CNT_W'(OFF_TICKS + 1));

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)
            cnt <= '0;
        else if (step)
            cnt <= ev.last ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/pgt_ctrl.sv
module pgt_ctrl
    import pgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  pgt_mode_e   mode,
    input  pgt_ctr_ev_t ev,
    input  logic        done_rise,
    input  logic        man_rise,
    input  logic        man_level,
    output logic        drv,
    output logic        ack,
    output logic        missed,
    output pgt_ctl_t    ctl
);

    pgt_state_e st, st_nxt;
    logic done_ok;
    logic fresh;

    assign done_ok = done_rise & ~man_level;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_UNCFG: if (go) st_nxt = ST_ON;
            ST_ON:    if (ev.cut || done_ok) st_nxt = ST_OFF;
            ST_OFF: begin
                if (man_rise)
                    st_nxt = ST_ON;
                else if (ev.last)
                    st_nxt = (mode == MODE_PERIODIC) ? ST_ON : ST_PARK;
            end
            ST_PARK:  if (man_rise) st_nxt = ST_ON;
            default:  st_nxt = ST_UNCFG;
        endcase
    end

    assign fresh = (st_nxt == ST_ON) && (st != ST_ON);

    always_comb begin
        ctl.clr = fresh;
        ctl.run = (st == ST_ON) || (st == ST_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_UNCFG;
            drv    <= 1'b0;
            ack    <= 1'b0;
            missed <= 1'b0;
        end else begin
            st  <= st_nxt;
            drv <= (st_nxt == ST_ON);
            if (fresh)
                ack <= 1'b0;
            else if (st == ST_ON && done_ok)
                ack <= 1'b1;
            if (st == ST_OFF && !man_rise && ev.last)
                missed <= ~ack;
        end
    end

endmodule

// File: rtl/pgt_timer_top.sv
module pgt_timer_top
    import pgt_pkg::*;
#(
    parameter int MIN_TICKS   = 100,
    parameter int MAX_TICKS   = 7200000,
    parameter int OFF_TICKS   = 50,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cfg_valid,
    input  logic             cfg_periodic,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             done_in,
    input  logic             man_start,
    output logic             drv_en,
    output logic             cfg_locked,
    output logic             ack_seen,
    output logic             no_ack
);

    logic             go;
    pgt_mode_e        mode;
    logic [CNT_W-1:0] len;
    logic             done_lvl, done_rise;
    logic             man_lvl, man_rise;
    pgt_ctr_ev_t      ev;
    pgt_ctl_t         ctl;

    pgt_cfg_latch #(
        .MIN_TICKS(MIN_TICKS),
        .MAX_TICKS(MAX_TICKS)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_periodic(cfg_periodic),
        .cfg_interval(cfg_interval), .go(go), .locked(cfg_locked), .mode(mode), .len(len)
    );

    pgt_edge_det #(.STAGES(SYNC_STAGES)) u_done (
        .clk(clk), .rst(rst), .d_in(done_in), .level(done_lvl), .rise(done_rise)
    );

    pgt_edge_det #(.STAGES(0)) u_man (
        .clk(clk), .rst(rst), .d_in(man_start), .level(man_lvl), .rise(man_rise)
    );

    pgt_interval_ctr #(
        .MAX_TICKS(MAX_TICKS),
        .OFF_TICKS(OFF_TICKS)
    ) u_ctr (
        .clk(clk), .rst(rst), .ctl(ctl), .tick(tick), .len(len), .ev(ev)
    );

    pgt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .go(go), .mode(mode), .ev(ev),
        .done_rise(done_rise), .man_rise(man_rise), .man_level(man_lvl),
        .drv(drv_en), .ack(ack_seen), .missed(no_ack), .ctl(ctl)
    );

    logic unused_lvl;
    assign unused_lvl = done_lvl;

endmodule

// File: rtl/pgt_timer_chk.sv
module pgt_timer_chk
    import pgt_pkg::*;
#(
    parameter int MIN_TICKS = 100,
    parameter int MAX_TICKS = 7200000,
    parameter int OFF_TICKS = 50,
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cfg_valid,
    input logic             cfg_periodic,
    input logic [CNT_W-1:0] cfg_interval,
    input logic             done_in,
    input logic             man_start,
    input logic             drv_en,
    input logic             cfg_locked,
    input logic             ack_seen,
    input logic             no_ack
);

    logic [CNT_W-1:0] c_len;
    logic [CNT_W-1:0] c_hi;
    logic             c_periodic;
    logic             c_done_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_len      <= CNT_W'(MIN_TICKS);
            c_periodic <= 1'b0;
        end else if (cfg_valid && !cfg_locked) begin
            c_len      <= CNT_W'(pgt_clamp(32'(cfg_interval), 32'(MIN_TICKS), 32'(MAX_TICKS)));
            c_periodic <= cfg_periodic;
        end
    end

    // ticks seen while the enable has been high, and DONE seen high during the pulse
    always_ff @(posedge clk) begin
        if (rst || !drv_en) begin
            c_hi        <= '0;
            c_done_seen <= 1'b0;
        end else begin
            if (tick)
                c_hi <= c_hi + CNT_W'(1);
            if (done_in)
                c_done_seen <= 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !drv_en && !cfg_locked && !ack_seen && !no_ack);

    p_rise_locked_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> cfg_locked);

    p_on_limit_r3: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (c_hi < c_len - CNT_W'(OFF_TICKS)));

    p_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
        ack_seen |-> !drv_en);

    p_ack_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_seen) |-> c_done_seen);

    p_single_rise_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_locked && $past(cfg_locked) && !c_periodic && $rose(drv_en)
        |-> $past(man_start) && !$past(man_start, 2));

    p_manual_masks_done_r7: assert property (@(posedge clk) disable iff (rst)
        drv_en && man_start && !(tick && c_hi == c_len - CNT_W'(OFF_TICKS + 1)) |=> drv_en);

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_locked |=> cfg_locked);

    p_ack_fresh_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> !ack_seen);

    p_miss_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(no_ack) |-> !$past(ack_seen));

    p_forced_fall_tick_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) && !ack_seen |-> $past(tick));

endmodule

bind pgt_timer_top pgt_timer_chk #(
    .MIN_TICKS(MIN_TICKS),
    .MAX_TICKS(MAX_TICKS),
    .OFF_TICKS(OFF_TICKS)
) u_chk (.*);

// File: tb/sim_pgt_timer_top.sv
`timescale 1ns/1ps
module sim_pgt_timer_top;

    localparam int MINT = 100;
    localparam int MAXT = 7200000;
    localparam int OFFT = 50;
    localparam int CW   = $clog2(MAXT + 1);
    localparam int NVEC = 7;
    // mode (1 periodic), interval, DONE at high sample, second DONE at low sample
    localparam int VEC [NVEC][4] = '{
        '{1, 100,  0,  0},
        '{1, 120, 10,  0},
        '{1,  99,  0,  0},
        '{0, 100,  0,  0},
        '{0, 150, 30,  0},
        '{1, 100, 48,  0},
        '{1, 130,  5, 20}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic cfg_valid = 1'b0;
    logic cfg_periodic = 1'b0;
    logic [CW-1:0] cfg_interval = '0;
    logic done_in = 1'b0;
    logic man_start = 1'b0;
    logic drv_en, cfg_locked, ack_seen, no_ack;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick = 1'b1;
        end else begin
            tick_cnt = (tick_cnt + 1) % tick_div;
            tick = (tick_cnt == 0);
        end
    end

    pgt_timer_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .cfg_valid(cfg_valid),
        .cfg_periodic(cfg_periodic), .cfg_interval(cfg_interval),
        .done_in(done_in), .man_start(man_start), .drv_en(drv_en),
        .cfg_locked(cfg_locked), .ack_seen(ack_seen), .no_ack(no_ack)
    );

    function automatic int blen(input int v);
        if (v < MINT) return MINT;
        if (v > MAXT) return MAXT;
        return v;
    endfunction

    function automatic int exp_hi(input int len, input int d);
        int full = len - OFFT;
        if (d == 0) return full;
        return (d + 2 < full) ? d + 2 : full;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_valid = 1'b0;
        cfg_periodic = 1'b0;
        cfg_interval = '0;
        done_in = 1'b0;
        man_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic configure(input int m, input int len);
        cfg_periodic = m[0];
        cfg_interval = CW'(len);
        cfg_valid = 1'b1;
        @(negedge clk);
    endtask

    // starts at a negedge with the enable high; ends at the first high sample
    // of the next pulse or once lim low samples are counted
    task automatic measure(input int d, input int d2, input int lim,
                           output int h, output int l, output int r);
        h = 0;
        l = 0;
        while (drv_en && h < 100000) begin
            h++;
            if (d != 0 && h == d) done_in = 1'b1;
            @(negedge clk);
        end
        while (!drv_en && l < lim) begin
            l++;
            if (l == 3) done_in = 1'b0;
            if (d2 != 0 && l == d2) done_in = 1'b1;
            if (d2 != 0 && l == d2 + 3) done_in = 1'b0;
            @(negedge clk);
        end
        r = drv_en ? 1 : 0;
    endtask

    initial begin
        int h, l, r, len;
        string tag;

        // reset state (R1)
        @(negedge clk);
        chk("R1", "drv_en in reset", drv_en, 0);
        do_reset();
        repeat (30) @(negedge clk);
        chk("R1", "drv_en before config", drv_en, 0);
        chk("R1", "cfg_locked before config", cfg_locked, 0);
        chk("R10", "no_ack before config", no_ack, 0);
        configure(1, 100);
        chk("R1", "drv_en after config", drv_en, 1);
        chk("R1", "cfg_locked after config", cfg_locked, 1);

        // table of modes, intervals and DONE timing
        for (int i = 0; i < NVEC; i++) begin
            len = blen(VEC[i][1]);
            tag = (VEC[i][2] == 0) ? "R3" : "R4";
            do_reset();
            configure(VEC[i][0], VEC[i][1]);
            chk("R1", "start high", drv_en, 1);
            measure(VEC[i][2], VEC[i][3], len + 40, h, l, r);
            chk(tag, $sformatf("vec %0d high ticks", i), h, exp_hi(len, VEC[i][2]));
            if (VEC[i][0] == 1) begin
                chk(VEC[i][1] < MINT ? "R2/R9" : "R2", $sformatf("vec %0d period", i), h + l, len);
            end else begin
                chk("R5", $sformatf("vec %0d no second pulse", i), r, 0);
            end
            chk("R10", $sformatf("vec %0d no_ack", i), no_ack, (VEC[i][2] == 0) ? 1 : 0);
        end

        // later configuration strobes are ignored (R8)
        do_reset();
        configure(1, 100);
        repeat (10) @(negedge clk);
        cfg_valid = 1'b0;
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_periodic = 1'b0;
        cfg_interval = CW'(200);
        @(negedge clk);
        measure(0, 0, 300, h, l, r);
        chk("R8", "mode kept periodic", r, 1);
        measure(0, 0, 300, h, l, r);
        chk("R8", "interval kept high", h, 50);
        chk("R8", "interval kept period", h + l, 100);

        // DONE while manual input held high is ignored (R7)
        do_reset();
        configure(1, 100);
        man_start = 1'b1;
        measure(5, 0, 200, h, l, r);
        chk("R7", "high ticks with masked DONE", h, 50);
        chk("R7", "no_ack after masked DONE", no_ack, 1);
        man_start = 1'b0;

        // single shot: manual start while high ignored, while parked accepted (R6)
        do_reset();
        configure(0, 100);
        measure(0, 0, 60, h, l, r);
        chk("R5", "single first pulse", h, 50);
        chk("R5", "single parked", r, 0);
        man_start = 1'b1;
        @(negedge clk);
        man_start = 1'b0;
        chk("R6", "manual start raises enable", drv_en, 1);
        h = 0;
        while (drv_en && h < 200) begin
            h++;
            man_start = (h == 10);
            @(negedge clk);
        end
        man_start = 1'b0;
        chk("R6", "manual start while high ignored", h, 50);
        l = 0;
        while (!drv_en && l < 100) begin
            l++;
            @(negedge clk);
        end
        chk("R5", "parked after manual pulse", drv_en, 0);
        man_start = 1'b1;
        @(negedge clk);
        man_start = 1'b0;
        measure(20, 0, 100, h, l, r);
        chk("R4", "manual pulse ended by DONE", h, 22);
        chk("R10", "ack_seen after DONE", ack_seen, 1);
        chk("R10", "no_ack after acked interval", no_ack, 0);
        chk("R5", "parked after acked pulse", r, 0);

        // periodic: manual start in rest window restarts the count (R6)
        do_reset();
        configure(1, 100);
        measure(0, 0, 10, h, l, r);
        chk("R3", "periodic first pulse", h, 50);
        man_start = 1'b1;
        @(negedge clk);
        man_start = 1'b0;
        chk("R6", "restart raises enable", drv_en, 1);
        measure(0, 0, 200, h, l, r);
        chk("R6", "restart high ticks", h, 50);
        chk("R6", "restart period", h + l, 100);

        // counting only on tick (R11)
        tick_div = 3;
        do_reset();
        configure(1, 100);
        measure(0, 0, 1000, h, l, r);
        measure(0, 0, 1000, h, l, r);
        chk("R11", "high cycles with slow tick", h, 150);
        chk("R11", "period cycles with slow tick", h + l, 300);
        tick_div = 1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule